// File: doc/BRIEF.md
# Boundary-Scan Cell Chain

This block is a row of boundary-scan cells of the two-flop kind, placed between a set of parallel inputs and the matching parallel outputs of a device. Every cell has a scan stage and a hold stage. The scan stage can take a snapshot of its parallel input or pass bits along a serial path to the next cell. The hold stage keeps a value that can be driven onto the parallel output in place of the live input.

Taking a snapshot and shifting it out never touch the parallel pass-through while the output select is low. Live values can therefore be sampled and read out serially while the device keeps running. All strobes come from the test clock, which is separate from any system clock. The test controller that would normally drive these strobes lies outside this block, and a bench drives them directly.

Top module: `bscan_chain`

## Requirements
- R1: An asynchronous active-low `trst_n` clears every scan flop and every hold flop to 0. After reset, `scan_out` reads 0, and `par_out` reads all zeros when `out_sel` is 1.
- R2: While `out_sel` is 0, `par_out[i]` equals `par_in[i]` combinationally, in the same cycle, for every cell i.
- R3: While `out_sel` is 1, `par_out[i]` equals cell i's hold flop and does not follow changes on `par_in`.
- R4: On a rising `tck` edge with `scan_en`=1 and `shift_sel`=0, every scan flop i loads `par_in[i]`.
- R5: On a rising `tck` edge with `scan_en`=1 and `shift_sel`=1, scan flop 0 loads `scan_in` and scan flop i loads scan flop i-1. `scan_out` is always scan flop N-1. Shifting N bits in, highest-index bit first, leaves bit i in cell i.
- R6: On an edge with `scan_en`=0, the scan flops keep their values, whatever `shift_sel`, `scan_in` and `par_in` are doing.
- R7: On an edge with `upd_en`=1, every hold flop loads its cell's scan flop at the same moment. With `upd_en`=0, the hold flops keep their values.
- R8: Capture and shift edges leave `par_out` equal to `par_in` while `out_sel` is 0.
- R9: When `scan_en` and `upd_en` are both 1 on the same edge, the hold flops take the scan values from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock. All flops use its rising edge. |
| trst_n | input | 1 | Asynchronous active-low test reset. |
| scan_en | input | 1 | Capture/shift strobe. The scan flops load only when it is high. |
| shift_sel | input | 1 | Selects the scan flop source: 1 serial, 0 parallel. |
| upd_en | input | 1 | Update strobe. Copies the scan flops into the hold flops. |
| out_sel | input | 1 | Selects the output source: 1 hold flops, 0 live inputs. |
| scan_in | input | 1 | Serial input into cell 0. |
| par_in | input | NUM_CELLS | Parallel inputs, one bit per cell. |
| par_out | output | NUM_CELLS | Parallel outputs, one bit per cell. |
| scan_out | output | 1 | Serial output, taken from the last cell. |

## Verification
The properties assume that every control input is a clean level sampled at the rising test-clock edge. They also assume that `par_in` and `scan_in` are known, non-X values from time zero, because the capture and shift checks compare flop contents with the previous cycle's inputs. The stimulus changes inputs only one time unit after each rising edge and drives every input during reset. Outputs are compared at the falling edge, which keeps sampling clear of the flop updates. Strobes are single-cycle pulses. Combined strobes appear only in the deliberate case where capture and update share an edge.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    // Action taken by the scan stage on one test-clock edge
    typedef enum logic [1:0] {
        SCAN_KEEP    = 2'd0,
        SCAN_SAMPLE  = 2'd1,
        SCAN_SERIAL  = 2'd2
    } scan_op_e;

    function automatic scan_op_e decode_scan_op(input logic en, input logic ser);
        if (!en)
            return SCAN_KEEP;
        else if (ser)
            return SCAN_SERIAL;
        else
            return SCAN_SAMPLE;
    endfunction

endpackage

// File: rtl/bscan_scan_stage.sv
module bscan_scan_stage
    import bscan_pkg::*;
#(
    parameter int NUM_CELLS = 8
) (
    input  logic                 tck,
    input  logic                 trst_n,
    input  logic                 scan_en,
    input  logic                 shift_sel,
    input  logic                 scan_in,
    input  logic [NUM_CELLS-1:0] par_in,
    output logic [NUM_CELLS-1:0] cap_q,
    output logic                 scan_out
);
    localparam int LAST = NUM_CELLS - 1;

    typedef struct packed {
        logic [NUM_CELLS-1:0] cells;
    } scan_state_t;

    scan_state_t st_d, st_q;
    logic [NUM_CELLS-1:0] ser_src;
    scan_op_e op;

    // Fixed serial path: each cell is fed by its lower neighbour
    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_ser
        if (i == 0) begin : g_head
            assign ser_src[i] = scan_in;
        end else begin : g_link
            assign ser_src[i] = st_q.cells[i-1];
        end
    end

    always_comb begin
        st_d = st_q;
        op   = decode_scan_op(scan_en, shift_sel);
        unique case (op)
            SCAN_SAMPLE: st_d.cells = par_in;
            SCAN_SERIAL: st_d.cells = ser_src;
            default:     st_d.cells = st_q.cells;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cap_q    = st_q.cells;
    assign scan_out = st_q.cells[LAST];

endmodule

// File: rtl/bscan_hold_stage.sv
module bscan_hold_stage #(
    parameter int NUM_CELLS = 8
) (
    input  logic                 tck,
    input  logic                 trst_n,
    input  logic                 upd_en,
    input  logic [NUM_CELLS-1:0] cap_q,
    output logic [NUM_CELLS-1:0] upd_q
);
    typedef struct packed {
        logic [NUM_CELLS-1:0] held;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_en)
            st_d.held = cap_q;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign upd_q = st_q.held;

endmodule

// File: rtl/bscan_out_select.sv
module bscan_out_select #(
    parameter int NUM_CELLS = 8
) (
    input  logic                 out_sel,
    input  logic [NUM_CELLS-1:0] par_in,
    input  logic [NUM_CELLS-1:0] upd_q,
    output logic [NUM_CELLS-1:0] par_out
);
    // One output multiplexer per cell, purely combinational
    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell_mux
        always_comb begin
            par_out[i] = out_sel ? upd_q[i] : par_in[i];
        end
    end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
    parameter int NUM_CELLS = 8
) (
    input  logic                 tck,
    input  logic                 trst_n,
    input  logic                 scan_en,
    input  logic                 shift_sel,
    input  logic                 upd_en,
    input  logic                 out_sel,
    input  logic                 scan_in,
    input  logic [NUM_CELLS-1:0] par_in,
    output logic [NUM_CELLS-1:0] par_out,
    output logic                 scan_out
);
    logic [NUM_CELLS-1:0] cap_q;
    logic [NUM_CELLS-1:0] upd_q;

    bscan_scan_stage #(.NUM_CELLS(NUM_CELLS)) u_scan (
        .tck       (tck),
        .trst_n    (trst_n),
        .scan_en   (scan_en),
        .shift_sel (shift_sel),
        .scan_in   (scan_in),
        .par_in    (par_in),
        .cap_q     (cap_q),
        .scan_out  (scan_out)
    );

    bscan_hold_stage #(.NUM_CELLS(NUM_CELLS)) u_hold (
        .tck    (tck),
        .trst_n (trst_n),
        .upd_en (upd_en),
        .cap_q  (cap_q),
        .upd_q  (upd_q)
    );

    bscan_out_select #(.NUM_CELLS(NUM_CELLS)) u_osel (
        .out_sel (out_sel),
        .par_in  (par_in),
        .upd_q   (upd_q),
        .par_out (par_out)
    );

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
    parameter int NUM_CELLS = 8
) (
    input logic                 tck,
    input logic                 trst_n,
    input logic                 scan_en,
    input logic                 shift_sel,
    input logic                 upd_en,
    input logic                 out_sel,
    input logic                 scan_in,
    input logic [NUM_CELLS-1:0] par_in,
    input logic [NUM_CELLS-1:0] par_out,
    input logic                 scan_out,
    input logic [NUM_CELLS-1:0] cap_q,
    input logic [NUM_CELLS-1:0] upd_q
);
    // R4
    capture_loads_inputs_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (scan_en && !shift_sel) |=> (cap_q == $past(par_in)));

    // R5
    shift_head_takes_serial_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (scan_en && shift_sel) |=> (cap_q[0] == $past(scan_in)));

    // R5
    shift_tail_moves_out_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (scan_en && shift_sel) |=> (scan_out == $past(cap_q[NUM_CELLS-1-((NUM_CELLS > 1) ? 1 : 0)])
                                    || (NUM_CELLS == 1)));

    // R6
    scan_idle_holds_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !scan_en |=> $stable(cap_q));

    // R7
    update_copies_chk: assert property (@(posedge tck) disable iff (!trst_n)
        upd_en |=> (upd_q == $past(cap_q)));

    // R7
    hold_keeps_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !upd_en |=> $stable(upd_q));

    // R3
    held_drives_out_chk: assert property (@(posedge tck) disable iff (!trst_n)
        out_sel |-> (par_out == upd_q));

    // R8
    passthrough_undisturbed_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (!out_sel && scan_en) |-> (par_out == par_in));

endmodule

bind bscan_chain bscan_chain_chk #(.NUM_CELLS(NUM_CELLS)) u_chk (
    .tck       (tck),
    .trst_n    (trst_n),
    .scan_en   (scan_en),
    .shift_sel (shift_sel),
    .upd_en    (upd_en),
    .out_sel   (out_sel),
    .scan_in   (scan_in),
    .par_in    (par_in),
    .par_out   (par_out),
    .scan_out  (scan_out),
    .cap_q     (cap_q),
    .upd_q     (upd_q)
);

// File: tb/bscan_chain_bench.sv
module bscan_chain_bench;
    localparam int N = 8;

    logic         tck = 1'b0;
    logic         trst_n = 1'b0;
    logic         scan_en = 1'b0;
    logic         shift_sel = 1'b0;
    logic         upd_en = 1'b0;
    logic         out_sel = 1'b0;
    logic         scan_in = 1'b0;
    logic [N-1:0] par_in = '0;
    logic [N-1:0] par_out;
    logic         scan_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        string        tag;
        bit           is_serial;
        logic [N-1:0] exp;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #10 tck = ~tck;

    bscan_chain #(.NUM_CELLS(N)) u_bscan_chain (
        .tck(tck), .trst_n(trst_n), .scan_en(scan_en), .shift_sel(shift_sel),
        .upd_en(upd_en), .out_sel(out_sel), .scan_in(scan_in),
        .par_in(par_in), .par_out(par_out), .scan_out(scan_out)
    );

    // Monitor: pops one expectation per falling edge and compares
    initial begin
        forever begin
            @(negedge tck);
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_run++;
                if (it.is_serial) begin
                    if (scan_out !== it.exp[0]) begin
                        n_fail++;
                        $display("FAIL %s scan_out actual=%b expected=%b", it.tag, scan_out, it.exp[0]);
                    end
                end else if (par_out !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s par_out actual=%h expected=%h", it.tag, par_out, it.exp);
                end
            end
        end
    end

    // Driver side: push an expectation and wait until the monitor consumed it
    task automatic expect_item(input string tag, input bit ser, input logic [N-1:0] exp);
        sb_item_t it;
        it.tag = tag; it.is_serial = ser; it.exp = exp;
        sb_q.push_back(it);
        while (sb_q.size() != 0) @(negedge tck);
        #1;
    endtask

    task automatic edge_op(input bit en, input bit ser, input bit upd, input bit sin);
        scan_en = en; shift_sel = ser; upd_en = upd; scan_in = sin;
        @(posedge tck); #1;
        scan_en = 1'b0; upd_en = 1'b0;
    endtask

    // Shift a word in highest bit first; checks each bit appearing at scan_out
    task automatic shift_word(input logic [N-1:0] w, input logic [N-1:0] old, input string tag);
        for (int k = 0; k < N; k++) begin
            expect_item(tag, 1'b1, {{(N-1){1'b0}}, old[N-1-k]});
            edge_op(1'b1, 1'b1, 1'b0, w[N-1-k]);
        end
    endtask

    initial begin
        // R1 / R2: during reset the outputs follow the inputs
        par_in = 8'hA5;
        expect_item("R2 reset pass", 1'b0, 8'hA5);
        @(posedge tck); #1;
        trst_n = 1'b1;
        out_sel = 1'b1;
        expect_item("R1 hold zero", 1'b0, 8'h00);
        expect_item("R1 scan zero", 1'b1, '0);

        // R2: pass-through across patterns
        out_sel = 1'b0;
        par_in = 8'h3C; expect_item("R2 pass 3C", 1'b0, 8'h3C);
        par_in = 8'hFF; expect_item("R2 pass FF", 1'b0, 8'hFF);

        // R4: snapshot, then R5 read it out while R8 par_in keeps flowing
        par_in = 8'hB6;
        edge_op(1'b1, 1'b0, 1'b0, 1'b0);
        par_in = 8'h5A;
        expect_item("R8 pass after capture", 1'b0, 8'h5A);
        shift_word(8'h4D, 8'hB6, "R4 R5 captured bit");
        expect_item("R8 pass after shift", 1'b0, 8'h5A);

        // R6: idle edges with serial select do not move the chain
        for (int k = 0; k < 3; k++) edge_op(1'b0, 1'b1, 1'b0, 1'b1);
        par_in = 8'h00;
        edge_op(1'b0, 1'b0, 1'b0, 1'b0);
        expect_item("R6 scan_out held", 1'b1, '0);

        // R7 / R3: update and drive the held word
        edge_op(1'b0, 1'b0, 1'b1, 1'b0);
        out_sel = 1'b1;
        expect_item("R3 R5 R6 held word", 1'b0, 8'h4D);
        par_in = 8'hE7;
        expect_item("R3 ignores par_in", 1'b0, 8'h4D);

        // R7: new shift without update leaves hold unchanged
        shift_word(8'h91, 8'h4D, "R5 old word out");
        expect_item("R7 hold kept", 1'b0, 8'h4D);
        edge_op(1'b0, 1'b0, 1'b1, 1'b0);
        expect_item("R7 update", 1'b0, 8'h91);

        // R9: capture and update on one edge
        par_in = 8'h0F;
        edge_op(1'b1, 1'b0, 1'b1, 1'b0);
        expect_item("R9 pre-edge value", 1'b0, 8'h91);
        edge_op(1'b0, 1'b0, 1'b1, 1'b0);
        expect_item("R9 then captured", 1'b0, 8'h0F);

        // R1: reset in mid operation
        trst_n = 1'b0;
        #2;
        expect_item("R1 reset hold", 1'b0, 8'h00);
        expect_item("R1 reset scan", 1'b1, '0);
        trst_n = 1'b1;

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule